// File: doc/BRIEF.md
# Interrupt and Exception Dispatch Unit

This block is the event-selection front end of a small processor core. Each cycle it looks at five kinds of request and picks one. The requests are a synchronous exception from the execute stage (tagged fault, trap or abort), a non-maskable interrupt, a software interrupt that carries a vector, a maskable external interrupt that carries a vector, and its own pending double-fault escalation. For the chosen event it works out which program counter to save and reads the handler address and privilege level from a 256-entry descriptor table held in registers. It then issues a one-cycle dispatch strobe.

The table entries are written through a simple write port. A separate load command sets the table base and the byte limit. No event is delivered until that load has been done. An entry counts as present only when its valid bit is set and its index is no more than the limit divided by the 8-byte entry size. An event whose entry is missing turns into a double fault on vector 8. If vector 8 is also missing, the block pulses a machine-reset output. A return command restores the saved program counter, the saved flags and the interrupt-enable state in one cycle.

Exception, NMI and software requests are one-cycle pulses, and the block keeps them pending until it serves them. The external request is a level that the source holds until it sees a dispatch of class external.

Top module: `irq_dispatch`

## Requirements
- R1: No event is dispatched until a table load (`ld_en`) has been seen. Requests raised before the load stay pending and are delivered after it.
- R2: A request sampled at a clock edge with a present entry produces `dsp_vld` for exactly one cycle, starting at that edge. The strobe carries the vector, the entry's handler address and privilege level, and `dsp_desc` = base + 8 × vector.
- R3: An entry is present only if its valid bit is set and vector ≤ limit / 8 (integer division). With limit 1607, vector 200 is present and vector 201 is not.
- R4: Saved PC (`dsp_spc`) depends on the event. A fault (`exc_kind`=0) saves `exc_pc`. A trap (`exc_kind`=1) saves `exc_npc`. An abort (`exc_kind`=2) saves `exc_pc` and sets the sticky `abort_seen`. A software interrupt saves `swi_npc`. NMI and external interrupts save `cur_pc`.
- R5: `dsp_cls` codes are 0 fault, 1 trap, 2 abort (this includes the double fault), 3 NMI, 4 software, 5 external. NMI always uses vector 2.
- R6: When several requests are pending, the order is: pending double-fault escalation, then exception, then NMI, then software interrupt, then external interrupt. Requests that lose are held and delivered in later cycles.
- R7: An external request is taken only while `ie` is 1. NMI and exceptions are delivered whatever the value of `ie`.
- R8: Any dispatch clears `ie` at the same edge. Otherwise `ie_set` sets it and `ie_clr` clears it.
- R9: A return request (`iret_req`) gives `ret_vld` for one cycle at the next edge. That strobe carries the PC saved by the last dispatch (`ret_pc`), the `cur_flags` value sampled at that dispatch (`ret_flags`), and puts `ie` back to its value before that dispatch. A return in the same cycle as a dispatch is dropped.
- R10: An event with a missing entry produces no strobe. One cycle later it is dispatched as vector 8, class abort, with the PC the failed event would have saved, and `abort_seen` is set. `abort_seen` clears only on `rst_n`.
- R11: If vector 8 is missing when the escalation is served, `mach_rst` pulses for one cycle with no dispatch. At the same edge `ie` is cleared, all pending requests are dropped, and a new table load is required before any delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | 8 | Entry index to write |
| tw_addr | input | 32 | Handler address for the entry |
| tw_dpl | input | 2 | Privilege level for the entry |
| tw_vld | input | 1 | Valid bit for the entry |
| ld_en | input | 1 | Table load: latch base and limit, enable delivery |
| ld_base | input | 32 | Table base address |
| ld_lim | input | 16 | Table byte limit |
| ie_set | input | 1 | Set interrupt enable |
| ie_clr | input | 1 | Clear interrupt enable |
| cur_pc | input | 32 | PC of the next instruction to execute |
| cur_flags | input | 8 | Current flags word |
| exc_req | input | 1 | Exception request pulse |
| exc_vec | input | 8 | Exception vector |
| exc_kind | input | 2 | 0 fault, 1 trap, 2 abort |
| exc_pc | input | 32 | Address of the excepting instruction |
| exc_npc | input | 32 | Address of the following instruction |
| nmi_req | input | 1 | Non-maskable interrupt pulse |
| swi_req | input | 1 | Software interrupt pulse |
| swi_vec | input | 8 | Software interrupt vector |
| swi_npc | input | 32 | Return address for the software interrupt |
| ext_req | input | 1 | Maskable external request level |
| ext_vec | input | 8 | External interrupt vector |
| iret_req | input | 1 | Return-from-interrupt pulse |
| dsp_vld | output | 1 | Dispatch strobe |
| dsp_vec | output | 8 | Dispatched vector |
| dsp_cls | output | 3 | Event class |
| dsp_hnd | output | 32 | Handler address |
| dsp_dpl | output | 2 | Entry privilege level |
| dsp_desc | output | 32 | Descriptor address |
| dsp_spc | output | 32 | Saved PC |
| ret_vld | output | 1 | Return strobe |
| ret_pc | output | 32 | Restored PC |
| ret_flags | output | 8 | Restored flags |
| ie | output | 1 | Interrupt enable state |
| abort_seen | output | 1 | Sticky abort indication |
| mach_rst | output | 1 | Machine reset pulse (triple fault) |

## Verification
A bad present-entry decision shows up one cycle after the request. The bench sees either a strobe with the wrong handler where a double fault was due, or a missing strobe where a handler was due. A stuck escalation or pending flag shows up as events out of priority order or as an extra or missing strobe within two or three cycles. A wrong saved-state register is hidden until the next return. It then shows in `ret_pc`, `ret_flags` or `ie` one cycle after `iret_req`, which is why the bench pairs a dispatch with a return.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NVEC = 256,
  parameter int AW   = 32,
  parameter int FW   = 8,
  parameter int LW   = 16,
  parameter int ESZ  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tw_en,
  input  logic [$clog2(NVEC)-1:0]  tw_idx,
  input  logic [AW-1:0]            tw_addr,
  input  logic [1:0]               tw_dpl,
  input  logic                     tw_vld,
  input  logic                     ld_en,
  input  logic [AW-1:0]            ld_base,
  input  logic [LW-1:0]            ld_lim,
  input  logic                     ie_set,
  input  logic                     ie_clr,
  input  logic [AW-1:0]            cur_pc,
  input  logic [FW-1:0]            cur_flags,
  input  logic                     exc_req,
  input  logic [$clog2(NVEC)-1:0]  exc_vec,
  input  logic [1:0]               exc_kind,
  input  logic [AW-1:0]            exc_pc,
  input  logic [AW-1:0]            exc_npc,
  input  logic                     nmi_req,
  input  logic                     swi_req,
  input  logic [$clog2(NVEC)-1:0]  swi_vec,
  input  logic [AW-1:0]            swi_npc,
  input  logic                     ext_req,
  input  logic [$clog2(NVEC)-1:0]  ext_vec,
  input  logic                     iret_req,
  output logic                     dsp_vld,
  output logic [$clog2(NVEC)-1:0]  dsp_vec,
  output logic [2:0]               dsp_cls,
  output logic [AW-1:0]            dsp_hnd,
  output logic [1:0]               dsp_dpl,
  output logic [AW-1:0]            dsp_desc,
  output logic [AW-1:0]            dsp_spc,
  output logic                     ret_vld,
  output logic [AW-1:0]            ret_pc,
  output logic [FW-1:0]            ret_flags,
  output logic                     ie,
  output logic                     abort_seen,
  output logic                     mach_rst
);
  localparam int VW  = $clog2(NVEC);
  localparam int ESH = $clog2(ESZ);
  localparam logic [VW-1:0] DF_VEC  = VW'(8);
  localparam logic [VW-1:0] NMI_VEC = VW'(2);
  localparam logic [2:0] C_FLT = 3'd0, C_TRP = 3'd1, C_ABT = 3'd2,
                         C_NMI = 3'd3, C_SWI = 3'd4, C_EXT = 3'd5;
  localparam logic [2:0] S_NONE = 3'd0, S_DF = 3'd1, S_EXC = 3'd2,
                         S_NMI = 3'd3, S_SWI = 3'd4, S_EXT = 3'd5;

  logic [AW-1:0] tab_addr [NVEC];
  logic [1:0]    tab_dpl  [NVEC];
  logic [NVEC-1:0] tab_v;

  logic [AW-1:0] base_q;
  logic [LW-1:0] lim_q;
  logic          loaded_q, ie_q;

  logic          exc_p, nmi_p, swi_p, df_p;
  logic [VW-1:0] ev_q, sv_vec_q;
  logic [1:0]    ek_q;
  logic [AW-1:0] epc_q, enpc_q, snpc_q, df_pc_q;

  logic [AW-1:0] sv_pc;
  logic [FW-1:0] sv_flags;
  logic          sv_ie;

  logic          exc_on, nmi_on, swi_on, ext_on;
  logic [VW-1:0] e_vec, s_vec_in;
  logic [1:0]    e_kind;
  logic [AW-1:0] e_pc, e_npc, s_npc;

  logic [2:0]    src;
  logic [VW-1:0] sel_vec;
  logic [2:0]    sel_cls;
  logic [AW-1:0] sel_pc;
  logic          go, hit, deliver, escal, triple;

  assign exc_on   = exc_req | exc_p;
  assign nmi_on   = nmi_req | nmi_p;
  assign swi_on   = swi_req | swi_p;
  assign ext_on   = ext_req & ie_q;
  assign e_vec    = exc_req ? exc_vec  : ev_q;
  assign e_kind   = exc_req ? exc_kind : ek_q;
  assign e_pc     = exc_req ? exc_pc   : epc_q;
  assign e_npc    = exc_req ? exc_npc  : enpc_q;
  assign s_vec_in = swi_req ? swi_vec  : sv_vec_q;
  assign s_npc    = swi_req ? swi_npc  : snpc_q;

  always_comb begin
    src     = S_NONE;
    sel_vec = '0;
    sel_cls = C_FLT;
    sel_pc  = '0;
    if (df_p) begin
      src = S_DF;  sel_vec = DF_VEC;   sel_cls = C_ABT; sel_pc = df_pc_q;
    end else if (exc_on) begin
      src = S_EXC; sel_vec = e_vec;
      sel_cls = (e_kind == 2'd1) ? C_TRP : (e_kind == 2'd2) ? C_ABT : C_FLT;
      sel_pc  = (e_kind == 2'd1) ? e_npc : e_pc;
    end else if (nmi_on) begin
      src = S_NMI; sel_vec = NMI_VEC;  sel_cls = C_NMI; sel_pc = cur_pc;
    end else if (swi_on) begin
      src = S_SWI; sel_vec = s_vec_in; sel_cls = C_SWI; sel_pc = s_npc;
    end else if (ext_on) begin
      src = S_EXT; sel_vec = ext_vec;  sel_cls = C_EXT; sel_pc = cur_pc;
    end
  end

  assign go      = loaded_q && (src != S_NONE);
  assign hit     = tab_v[sel_vec] && (LW'(sel_vec) <= (lim_q >> ESH));
  assign deliver = go && hit;
  assign escal   = go && !hit && (src != S_DF);
  assign triple  = go && !hit && (src == S_DF);

  always_ff @(posedge clk) begin
    if (tw_en) begin
      tab_addr[tw_idx] <= tw_addr;
      tab_dpl[tw_idx]  <= tw_dpl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tab_v <= '0;
    else if (tw_en) tab_v[tw_idx] <= tw_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; lim_q <= '0; loaded_q <= 1'b0; ie_q <= 1'b0;
      exc_p <= 1'b0; nmi_p <= 1'b0; swi_p <= 1'b0; df_p <= 1'b0;
      ev_q <= '0; ek_q <= '0; epc_q <= '0; enpc_q <= '0;
      sv_vec_q <= '0; snpc_q <= '0; df_pc_q <= '0;
      sv_pc <= '0; sv_flags <= '0; sv_ie <= 1'b0;
      dsp_vld <= 1'b0; dsp_vec <= '0; dsp_cls <= '0; dsp_hnd <= '0;
      dsp_dpl <= '0; dsp_desc <= '0; dsp_spc <= '0;
      ret_vld <= 1'b0; ret_pc <= '0; ret_flags <= '0;
      abort_seen <= 1'b0; mach_rst <= 1'b0;
    end else begin
      if (exc_req) begin
        ev_q <= exc_vec; ek_q <= exc_kind; epc_q <= exc_pc; enpc_q <= exc_npc;
      end
      if (swi_req) begin
        sv_vec_q <= swi_vec; snpc_q <= swi_npc;
      end
      if (ld_en) begin
        base_q <= ld_base; lim_q <= ld_lim;
      end

      if (triple) begin
        exc_p <= 1'b0; nmi_p <= 1'b0; swi_p <= 1'b0; df_p <= 1'b0;
        loaded_q <= 1'b0;
      end else begin
        exc_p    <= exc_on && !(go && src == S_EXC);
        nmi_p    <= nmi_on && !(go && src == S_NMI);
        swi_p    <= swi_on && !(go && src == S_SWI);
        df_p     <= escal;
        loaded_q <= loaded_q | ld_en;
      end
      if (escal) df_pc_q <= sel_pc;

      if (triple || deliver) ie_q <= 1'b0;
      else if (iret_req)     ie_q <= sv_ie;
      else if (ie_set)       ie_q <= 1'b1;
      else if (ie_clr)       ie_q <= 1'b0;

      dsp_vld <= deliver;
      if (deliver) begin
        dsp_vec  <= sel_vec;
        dsp_cls  <= sel_cls;
        dsp_hnd  <= tab_addr[sel_vec];
        dsp_dpl  <= tab_dpl[sel_vec];
        dsp_desc <= base_q + (AW'(sel_vec) << ESH);
        dsp_spc  <= sel_pc;
        sv_pc    <= sel_pc;
        sv_flags <= cur_flags;
        sv_ie    <= ie_q;
      end

      ret_vld <= iret_req && !deliver && !triple;
      if (iret_req && !deliver && !triple) begin
        ret_pc    <= sv_pc;
        ret_flags <= sv_flags;
      end

      abort_seen <= abort_seen | (deliver && sel_cls == C_ABT);
      mach_rst   <= triple;
    end
  end

  assign ie = ie_q;
endmodule

module irq_dispatch_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dsp_vld,
  input logic [2:0]    dsp_cls,
  input logic [VW-1:0] dsp_vec,
  input logic          ie,
  input logic          ret_vld,
  input logic          mach_rst,
  input logic          abort_seen,
  input logic          loaded
);
  AST_NO_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n) dsp_vld |-> $past(loaded)); // R1
  AST_EXT_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (dsp_vld && dsp_cls == 3'd5) |-> $past(ie)); // R7
  AST_IE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) dsp_vld |-> !ie); // R8
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) (dsp_vld && dsp_cls == 3'd3) |-> dsp_vec == VW'(2)); // R5
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (dsp_vld && dsp_cls == 3'd2) |-> abort_seen); // R4
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) abort_seen |=> abort_seen); // R10
  AST_RET_ALONE: assert property (@(posedge clk) disable iff (!rst_n) ret_vld |-> !dsp_vld); // R9
  AST_TRIPLE_STATE: assert property (@(posedge clk) disable iff (!rst_n) mach_rst |-> (!dsp_vld && !ie && !loaded)); // R11
  AST_TRIPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mach_rst |=> !mach_rst); // R11
endmodule

bind irq_dispatch irq_dispatch_chk #(.VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dsp_vld(dsp_vld), .dsp_cls(dsp_cls),
  .dsp_vec(dsp_vec), .ie(ie), .ret_vld(ret_vld), .mach_rst(mach_rst),
  .abort_seen(abort_seen), .loaded(loaded_q)
);

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tw_en = 0, tw_vld = 0, ld_en = 0, ie_set = 0, ie_clr = 0;
  logic [7:0] tw_idx = 0, exc_vec = 0, swi_vec = 0, ext_vec = 0;
  logic [31:0] tw_addr = 0, ld_base = 0, cur_pc = 32'hC0DE_0040;
  logic [31:0] exc_pc = 0, exc_npc = 0, swi_npc = 0;
  logic [1:0] tw_dpl = 0, exc_kind = 0;
  logic [15:0] ld_lim = 0;
  logic [7:0] cur_flags = 8'h3C;
  logic exc_req = 0, nmi_req = 0, swi_req = 0, ext_req = 0, iret_req = 0;
  logic dsp_vld, ret_vld, ie, abort_seen, mach_rst;
  logic [7:0] dsp_vec, ret_flags;
  logic [2:0] dsp_cls;
  logic [1:0] dsp_dpl;
  logic [31:0] dsp_hnd, dsp_desc, dsp_spc, ret_pc;
  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] BASE = 32'h0000_8000;
  localparam logic [15:0] LIM = 16'd1607;

  always #2 clk = ~clk;

  irq_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_idx(tw_idx), .tw_addr(tw_addr),
    .tw_dpl(tw_dpl), .tw_vld(tw_vld), .ld_en(ld_en), .ld_base(ld_base), .ld_lim(ld_lim),
    .ie_set(ie_set), .ie_clr(ie_clr), .cur_pc(cur_pc), .cur_flags(cur_flags),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_kind(exc_kind), .exc_pc(exc_pc),
    .exc_npc(exc_npc), .nmi_req(nmi_req), .swi_req(swi_req), .swi_vec(swi_vec),
    .swi_npc(swi_npc), .ext_req(ext_req), .ext_vec(ext_vec), .iret_req(iret_req),
    .dsp_vld(dsp_vld), .dsp_vec(dsp_vec), .dsp_cls(dsp_cls), .dsp_hnd(dsp_hnd),
    .dsp_dpl(dsp_dpl), .dsp_desc(dsp_desc), .dsp_spc(dsp_spc), .ret_vld(ret_vld),
    .ret_pc(ret_pc), .ret_flags(ret_flags), .ie(ie), .abort_seen(abort_seen),
    .mach_rst(mach_rst)
  );

  function automatic logic [31:0] hnd_of(input int v);
    return 32'h1000_0004 + 32'(v) * 32'h40;
  endfunction
  function automatic bit present(input int v);
    return (v % 7 != 5) && (v <= int'(LIM) / 8);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_dsp(input string req, input int v, input logic [2:0] cls, input logic [31:0] spc);
    chk(dsp_vld == 1'b1, req, {31'd0, dsp_vld}, 32'd1);
    chk(dsp_vec == 8'(v), req, {24'd0, dsp_vec}, 32'(v));
    chk(dsp_cls == cls, req, {29'd0, dsp_cls}, {29'd0, cls});
    chk(dsp_spc == spc, req, dsp_spc, spc);
    chk(dsp_hnd == hnd_of(v), req, dsp_hnd, hnd_of(v));
  endtask

  task automatic wait_dsp(input string req);
    bit got = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      @(negedge clk);
      if (dsp_vld) got = 1;
    end
    chk(got, req, {31'd0, got}, 32'd1);
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dsp_vld == 1'b0, req, {31'd0, dsp_vld}, 32'd0);
    end
  endtask

  task automatic wr_ent(input int v, input bit vld);
    @(negedge clk);
    tw_en = 1; tw_idx = 8'(v); tw_addr = hnd_of(v); tw_dpl = 2'(v); tw_vld = vld;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic swi(input int v, input logic [31:0] npc);
    @(negedge clk);
    swi_req = 1; swi_vec = 8'(v); swi_npc = npc;
    @(negedge clk);
    swi_req = 0;
  endtask

  task automatic exc(input int v, input logic [1:0] k, input logic [31:0] pc);
    @(negedge clk);
    exc_req = 1; exc_vec = 8'(v); exc_kind = k; exc_pc = pc; exc_npc = pc + 4;
    @(negedge clk);
    exc_req = 0;
  endtask

  task automatic pulse_ie_set();
    @(negedge clk); ie_set = 1; @(negedge clk); ie_set = 0;
  endtask

  task automatic load();
    @(negedge clk); ld_en = 1; ld_base = BASE; ld_lim = LIM; @(negedge clk); ld_en = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!dsp_vld && !ie && !abort_seen && !mach_rst && !ret_vld, "R1 reset",
        {27'd0, dsp_vld, ie, abort_seen, mach_rst, ret_vld}, 32'd0);

    for (int v = 0; v < 256; v++) wr_ent(v, v % 7 != 5);

    swi(41, 32'h0000_2000);
    quiet("R1 held before load", 4);
    @(negedge clk); ld_en = 1; ld_base = BASE; ld_lim = LIM;
    @(negedge clk); ld_en = 0;
    chk(dsp_vld == 1'b0, "R1 load latency", {31'd0, dsp_vld}, 32'd0);
    @(negedge clk);
    chk_dsp("R1 pending after load", 41, 3'd4, 32'h0000_2000);

    exc(14, 2'd0, 32'h0000_0100);
    chk_dsp("R4 fault pc", 14, 3'd0, 32'h0000_0100);
    exc(3, 2'd1, 32'h0000_0200);
    chk_dsp("R4 trap pc", 3, 3'd1, 32'h0000_0204);
    chk(abort_seen == 1'b0, "R4 no abort yet", {31'd0, abort_seen}, 32'd0);
    exc(18, 2'd2, 32'h0000_0300);
    chk_dsp("R4 abort pc", 18, 3'd2, 32'h0000_0300);
    chk(abort_seen == 1'b1, "R4 abort sticky", {31'd0, abort_seen}, 32'd1);

    pulse_ie_set();
    @(negedge clk);
    exc_req = 1; exc_vec = 0; exc_kind = 0; exc_pc = 32'h400; exc_npc = 32'h404;
    nmi_req = 1; swi_req = 1; swi_vec = 34; swi_npc = 32'h500;
    ext_req = 1; ext_vec = 36;
    @(negedge clk);
    exc_req = 0; nmi_req = 0; swi_req = 0;
    chk_dsp("R6 exception first", 0, 3'd0, 32'h400);
    @(negedge clk);
    chk_dsp("R6 NMI second", 2, 3'd3, cur_pc);
    @(negedge clk);
    chk_dsp("R6 software third", 34, 3'd4, 32'h500);
    quiet("R7 external masked", 3);
    chk(ie == 1'b0, "R8 dispatch clears ie", {31'd0, ie}, 32'd0);
    pulse_ie_set();
    if (!dsp_vld) wait_dsp("R7 external after enable");
    chk_dsp("R7 external", 36, 3'd5, cur_pc);
    chk(dsp_desc == BASE + 32'd288, "R2 descriptor address", dsp_desc, BASE + 32'd288);
    chk(dsp_dpl == 2'd0, "R2 privilege", {30'd0, dsp_dpl}, 32'd0);
    ext_req = 0;
    chk(ie == 1'b0, "R8 ie after external", {31'd0, ie}, 32'd0);

    cur_flags = 8'h00;
    @(negedge clk); iret_req = 1; @(negedge clk); iret_req = 0;
    chk(ret_vld == 1'b1, "R9 return strobe", {31'd0, ret_vld}, 32'd1);
    chk(ret_pc == 32'hC0DE_0040, "R9 return pc", ret_pc, 32'hC0DE_0040);
    chk(ret_flags == 8'h3C, "R9 return flags", {24'd0, ret_flags}, 32'h3C);
    chk(ie == 1'b1, "R9 ie restored", {31'd0, ie}, 32'd1);
    @(negedge clk);
    chk(ret_vld == 1'b0, "R9 one cycle", {31'd0, ret_vld}, 32'd0);

    @(negedge clk); ie_clr = 1; @(negedge clk); ie_clr = 0;
    chk(ie == 1'b0, "R8 ie_clr", {31'd0, ie}, 32'd0);
    @(negedge clk); nmi_req = 1; @(negedge clk); nmi_req = 0;
    chk_dsp("R7 NMI ignores ie", 2, 3'd3, cur_pc);

    @(negedge clk); swi_req = 1; swi_vec = 5; swi_npc = 32'h600;
    @(negedge clk); swi_req = 0;
    exc_req = 1; exc_vec = 13; exc_kind = 0; exc_pc = 32'h700; exc_npc = 32'h704;
    chk(dsp_vld == 1'b0, "R10 no strobe on missing", {31'd0, dsp_vld}, 32'd0);
    @(negedge clk); exc_req = 0;
    chk_dsp("R6 double fault before exception", 8, 3'd2, 32'h600);
    @(negedge clk);
    chk_dsp("R6 held exception", 13, 3'd0, 32'h700);

    for (int v = 0; v < 256; v++) begin
      swi(v, 32'h0001_0000 + 32'(v));
      if (present(v)) begin
        chk_dsp("R2 R3 sweep hit", v, 3'd4, 32'h0001_0000 + 32'(v));
        chk(dsp_desc == BASE + 32'(v) * 8, "R2 sweep descriptor", dsp_desc, BASE + 32'(v) * 8);
        chk(dsp_dpl == 2'(v), "R2 sweep privilege", {30'd0, dsp_dpl}, 32'(v % 4));
      end else begin
        chk(dsp_vld == 1'b0, "R3 sweep missing", {31'd0, dsp_vld}, 32'd0);
        @(negedge clk);
        chk_dsp("R10 sweep double fault", 8, 3'd2, 32'h0001_0000 + 32'(v));
      end
      @(negedge clk);
      chk(dsp_vld == 1'b0, "R2 strobe one cycle", {31'd0, dsp_vld}, 32'd0);
    end
    chk(abort_seen == 1'b1, "R10 abort still set", {31'd0, abort_seen}, 32'd1);

    wr_ent(8, 1'b0);
    pulse_ie_set();
    swi(5, 32'h800);
    chk(dsp_vld == 1'b0 && mach_rst == 1'b0, "R11 first cycle", {30'd0, dsp_vld, mach_rst}, 32'd0);
    @(negedge clk);
    chk(mach_rst == 1'b1, "R11 reset pulse", {31'd0, mach_rst}, 32'd1);
    chk(dsp_vld == 1'b0, "R11 no dispatch", {31'd0, dsp_vld}, 32'd0);
    chk(ie == 1'b0, "R11 ie cleared", {31'd0, ie}, 32'd0);
    @(negedge clk);
    chk(mach_rst == 1'b0, "R11 pulse ends", {31'd0, mach_rst}, 32'd0);
    swi(41, 32'h900);
    quiet("R11 reload required", 4);
    load();
    if (!dsp_vld) wait_dsp("R11 after reload");
    chk_dsp("R11 delivered after reload", 41, 3'd4, 32'h900);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule